// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is a two-wire serial target that runs entirely in the system clock domain. It oversamples the bus clock and data lines, detects START and STOP conditions, and answers only to the 7-bit address 0x0E. Behind the bus engine sits a small 8-bit register file. It holds a control byte, a two-byte 10-bit coil current setpoint, a read-only status byte fed from outside, a mode byte and a resonance code.

The register pointer lives across transactions. A controller can set it once and then read "from where it was" without sending a pointer byte again. Every data byte, read or written, moves the pointer forward by one, so sequential bursts walk the map. The 10-bit current output is updated atomically only when the low byte is written, and that write produces a one-cycle commit pulse. Writing 1 to bit 0 of the control byte returns every register to its reset value and emits a one-cycle reset request. The bit itself always reads back as 0.

Top module: `i2c_reg_target`

## Requirements
- R1: The target acknowledges only the address byte {7'h0E, rw}, where rw=0 means write and rw=1 means read. After any other address it NACKs, never drives SDA, and ignores the bus until the next START, so no register changes.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Data bits are taken on SCL rising edges. A STOP in the middle of a byte discards that byte.
- R3: The target pulls SDA low for its ACK from the SCL falling edge after the 8th bit until the next SCL falling edge. It only begins driving SDA while SCL is low.
- R4: In a write, the first byte after the address loads the pointer. Each following data byte is written to the pointer location, and the pointer then increments by one.
- R5: A read transaction returns the byte at the current pointer. This holds both after a pointer set followed by a repeated START and with no pointer set at all. Each byte sent increments the pointer.
- R6: A sequential read continues while the controller ACKs. On a controller NACK the target releases SDA and sends no further byte.
- R7: After reset the register values are: 0x02 reads 0x02, 0x03 and 0x04 read 0x00, 0x06 reads 0x00 and 0x07 reads 0x83. 0x05 reads {3'b0, status_i}. Outputs are ring_en_o=1, current_o=0, mode_o=0 and res_code_o=0x83.
- R8: current_o changes only when a write to 0x04 completes. It then becomes {reg 0x03 bits 1:0, written byte} and commit_o pulses for one cycle. A write to 0x03 alone leaves current_o unchanged.
- R9: Writing 0x02 with bit 0 set returns all registers and outputs to their R7 values, whatever bit 1 holds. soft_rst_o pulses for exactly one cycle, and bit 0 reads back as 0.
- R10: Unused register bits read 0 and ignore writes. Writes to 0x05 and to any address other than 0x02, 0x03, 0x04, 0x06 and 0x07 are dropped but still advance the pointer, and undefined addresses read 0x00.
- R11: In register 0x06, bits 4:2 are the switching frequency code, bit 1 selects linear (1) or switched (0) drive, and bit 0 selects single-period ringing compensation. mode_o mirrors bits 4:0. Bit 1 of 0x02 drives ring_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| status_i | input | 5 | Status flags shown in register 0x05 |
| ring_en_o | output | 1 | Ringing compensation enable |
| current_o | output | 10 | Applied coil current setpoint |
| mode_o | output | 5 | Mode field: frequency code, drive select, ring mode |
| res_code_o | output | 8 | Resonance code |
| commit_o | output | 1 | One-cycle pulse when a new current is applied |
| soft_rst_o | output | 1 | One-cycle software reset request |

## Verification
The bench drives the bus as an open-drain controller against a behavioural register model. The patterns it uses separate the transaction types: a pointer set followed by a repeated-START read, bare current-location reads that prove the pointer survives a STOP, and multi-byte writes and reads that prove auto-increment. Other patterns tell a correct target apart from a faulty one at its edges: a foreign address, a STOP cut into a byte, writes to status and to unmapped addresses, and a high-byte-only current write against a full low-byte commit. A NACK-terminated read and a software reset carrying a conflicting enable bit close the sequence.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_st_e;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} byte_kind_e;

  localparam int unsigned STAT_W = 5;
  localparam int unsigned MODE_W = 5;

  localparam logic [7:0] OFS_CTRL   = 8'h02;
  localparam logic [7:0] OFS_CUR_HI = 8'h03;
  localparam logic [7:0] OFS_CUR_LO = 8'h04;
  localparam logic [7:0] OFS_STAT   = 8'h05;
  localparam logic [7:0] OFS_MODE   = 8'h06;
  localparam logic [7:0] OFS_RES    = 8'h07;

  localparam logic [7:0] RST_RES = 8'h83;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h0E
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o,
  output logic       idle_o
);
  bus_st_e    st;
  byte_kind_e kind;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rd, mack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      kind      <= K_ADDR;
      sh        <= '0;
      cnt       <= '0;
      rd        <= 1'b0;
      mack      <= 1'b0;
      ptr_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        st <= ST_IDLE;
      end else if (start_i) begin
        st   <= ST_RX;
        kind <= K_ADDR;
        cnt  <= '0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise_i) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              unique case (kind)
                K_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    rd <= sh[0];
                    st <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_PTR: begin
                  ptr_o <= sh;
                  st    <= ST_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr_o;
                  wr_data_o <= sh;
                  ptr_o     <= ptr_o + 8'd1;
                  st        <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (kind == K_ADDR && rd) begin
                sh    <= rd_data_i;
                ptr_o <= ptr_o + 8'd1;
                st    <= ST_TX;
              end else begin
                kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
                st   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              sh  <= {sh[6:0], 1'b0};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) st <= ST_MACK;
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack) begin
                sh    <= rd_data_i;
                ptr_o <= ptr_o + 8'd1;
                cnt   <= '0;
                st    <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = (st == ST_ACK) || (st == ST_TX && !sh[7]);
  assign idle_o   = (st == ST_IDLE);
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
  import i2c_reg_pkg::*;
#(
  parameter int unsigned CUR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [7:0]        rd_addr_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [7:0]        rd_data_o,
  output logic              ring_en_o,
  output logic [CUR_W-1:0]  current_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [7:0]        res_code_o,
  output logic              commit_o,
  output logic              soft_rst_o
);
  localparam int unsigned HI_W = CUR_W - 8;

  logic [HI_W-1:0] cur_hi;
  logic [7:0]      cur_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_en_o  <= 1'b1;
      cur_hi     <= '0;
      cur_lo     <= '0;
      current_o  <= '0;
      mode_o     <= '0;
      res_code_o <= RST_RES;
      commit_o   <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      commit_o   <= 1'b0;
      soft_rst_o <= 1'b0;
      if (wr_en_i) begin
        unique case (wr_addr_i)
          OFS_CTRL: begin
            if (wr_data_i[0]) begin
              ring_en_o  <= 1'b1;
              cur_hi     <= '0;
              cur_lo     <= '0;
              current_o  <= '0;
              mode_o     <= '0;
              res_code_o <= RST_RES;
              soft_rst_o <= 1'b1;
            end else begin
              ring_en_o <= wr_data_i[1];
            end
          end
          OFS_CUR_HI: cur_hi <= wr_data_i[HI_W-1:0];
          OFS_CUR_LO: begin
            cur_lo    <= wr_data_i;
            current_o <= {cur_hi, wr_data_i};
            commit_o  <= 1'b1;
          end
          OFS_MODE: mode_o     <= wr_data_i[MODE_W-1:0];
          OFS_RES:  res_code_o <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      OFS_CTRL:   rd_data_o = {6'b0, ring_en_o, 1'b0};
      OFS_CUR_HI: rd_data_o[HI_W-1:0] = cur_hi;
      OFS_CUR_LO: rd_data_o = cur_lo;
      OFS_STAT:   rd_data_o[STAT_W-1:0] = status_i;
      OFS_MODE:   rd_data_o[MODE_W-1:0] = mode_o;
      OFS_RES:    rd_data_o = res_code_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h0E,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CUR_W       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [STAT_W-1:0] status_i,
  output logic              ring_en_o,
  output logic [CUR_W-1:0]  current_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [7:0]        res_code_o,
  output logic              commit_o,
  output logic              soft_rst_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [7:0] ptr, rd_data, wr_addr, wr_data;
  logic wr_en, bus_idle;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .rd_data_i(rd_data), .ptr_o(ptr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o, .idle_o(bus_idle)
  );

  i2c_reg_file #(.CUR_W(CUR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(ptr), .status_i, .rd_data_o(rd_data), .ring_en_o, .current_o,
    .mode_o, .res_code_o, .commit_o, .soft_rst_o
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int unsigned CUR_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s_i,
  input logic             bus_idle_i,
  input logic             sda_oe_o,
  input logic             ring_en_o,
  input logic [CUR_W-1:0] current_o,
  input logic [4:0]       mode_o,
  input logic [7:0]       res_code_o,
  input logic             commit_o,
  input logic             soft_rst_o
);
  assert_drive_on_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o && !$past(sda_oe_o)) |-> !scl_s_i);

  assert_idle_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_idle_i) && bus_idle_i) |-> !sda_oe_o);

  assert_cur_only_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(current_o) |-> (commit_o || soft_rst_o));

  assert_commit_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  assert_soft_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  assert_soft_defaults_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (current_o == '0 && ring_en_o && mode_o == '0 && res_code_o == 8'h83 && !commit_o));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.CUR_W(CUR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .bus_idle_i(bus_idle),
  .sda_oe_o(sda_oe_o), .ring_en_o(ring_en_o), .current_o(current_o),
  .mode_o(mode_o), .res_code_o(res_code_o), .commit_o(commit_o),
  .soft_rst_o(soft_rst_o)
);

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h0E;
  localparam logic [4:0] STAT = 5'h15;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, ring_en, commit, soft_rst;
  logic [9:0] current;
  logic [4:0] mode;
  logic [7:0] res_code;
  wire sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  int commit_cnt = 0, soft_cnt = 0, oe_cnt = 0;
  bit hold = 1'b1, done = 1'b0;

  // behavioural model
  bit m_ring = 1'b1;
  logic [1:0] m_hi = '0;
  logic [7:0] m_lo = '0, m_res = 8'h83, m_ptr = '0;
  logic [4:0] m_mode = '0;
  logic [9:0] m_cur = '0;
  int exp_commit = 0, exp_soft = 0;

  always #10 clk = ~clk;

  i2c_reg_target uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .status_i(STAT), .ring_en_o(ring_en), .current_o(current), .mode_o(mode),
    .res_code_o(res_code), .commit_o(commit), .soft_rst_o(soft_rst)
  );

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h02: return {6'b0, m_ring, 1'b0};
      8'h03: return {6'b0, m_hi};
      8'h04: return m_lo;
      8'h05: return {3'b0, STAT};
      8'h06: return {3'b0, m_mode};
      8'h07: return m_res;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h02: if (d[0]) begin
               m_ring = 1; m_hi = 0; m_lo = 0; m_cur = 0; m_mode = 0; m_res = 8'h83;
               exp_soft++;
             end else m_ring = d[1];
      8'h03: m_hi = d[1:0];
      8'h04: begin m_lo = d; m_cur = {m_hi, d}; exp_commit++; end
      8'h06: m_mode = d[4:0];
      8'h07: m_res = d;
      default: ;
    endcase
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (commit) commit_cnt++;
      if (soft_rst) soft_cnt++;
      if (sda_oe) oe_cnt++;
      if (!hold && !done)
        chk("R8/R9/R11 outputs", {ring_en, current, mode, res_code},
            {m_ring, m_cur, m_mode, m_res});
    end
  end

  task automatic hw(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; hw(); scl = 1; hw(); scl = 0; hw();
  endtask

  task automatic bus_start();
    sda_m = 1; hw(); scl = 1; hw(); sda_m = 0; hw(); scl = 0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 0; hw(); scl = 1; hw(); sda_m = 1; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit a1, a2;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1; hw(); scl = 1;
    hw(Q/2); a1 = ~sda_line;
    hw(Q/2); a2 = ~sda_line;
    scl = 0; hw();
    ack = a1 & a2;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hw(); scl = 1; hw(Q/2); d = {d[6:0], sda_line}; hw(Q/2); scl = 0;
    end
    hw();
    put_bit(!mack);
  endtask

  logic [7:0] wq[$];

  task automatic do_write(input logic [7:0] p, input string r);
    bit ack;
    bus_start();
    send_byte({ADDR, 1'b0}, ack); chk({r, " R1 addr ack"}, ack, 1);
    send_byte(p, ack);            chk({r, " R3 ptr ack"}, ack, 1);
    m_ptr = p;
    foreach (wq[i]) begin
      hold = 1;
      send_byte(wq[i], ack);
      m_write(m_ptr, wq[i]);
      m_ptr++;
      hold = 0;
      chk({r, " R4 data ack"}, ack, 1);
    end
    bus_stop();
    wq.delete();
  endtask

  task automatic do_read(input bit set_ptr, input logic [7:0] p, input int n, input string r);
    bit ack;
    logic [7:0] d;
    bus_start();
    if (set_ptr) begin
      send_byte({ADDR, 1'b0}, ack); chk({r, " R1 addr ack"}, ack, 1);
      send_byte(p, ack);            chk({r, " R4 ptr ack"}, ack, 1);
      m_ptr = p;
      bus_start();
    end
    send_byte({ADDR, 1'b1}, ack); chk({r, " R1 read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(r, d, m_read(m_ptr));
      m_ptr++;
    end
    hw();
    chk({r, " R6 released after NACK"}, sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    hw(5);
    rst_n = 1;
    hw(2);
    chk("R7 reset current", current, 0);
    chk("R7 reset res_code", res_code, 8'h83);
    chk("R7 reset ring_en", ring_en, 1);
    chk("R7 reset mode", mode, 0);
    chk("R7 reset sda released", sda_oe, 0);
    hold = 0;

    // R7, R5, R6: reset map via pointer + repeated start, sequential
    do_read(1, 8'h02, 6, "R7 map");
    // R5: current-location read after STOP (ptr now 0x08)
    do_read(0, 8'h00, 1, "R5 current loc");

    // R11, R10: mode masking, sequential write
    wq = '{8'hFF, 8'h55};
    do_write(8'h06, "R11 mode");
    chk("R11 mode_o", mode, 5'h1F);
    do_read(1, 8'h06, 2, "R10 masked readback");

    // R8: high byte alone does not apply
    wq = '{8'h02};
    do_write(8'h03, "R8 hi only");
    chk("R8 no commit on hi", commit_cnt, 0);
    chk("R8 current held", current, 0);
    wq = '{8'h34};
    do_write(8'h04, "R8 lo");
    chk("R8 current applied", current, 10'h234);
    chk("R8 commit count", commit_cnt, 1);
    wq = '{8'h01, 8'h80};
    do_write(8'h03, "R8 seq");
    chk("R8 seq current", current, 10'h180);
    chk("R8 seq commit", commit_cnt, 2);

    // R10: writes across end of map and to status are dropped, pointer moves
    wq = '{8'h11, 8'h99};
    do_write(8'h07, "R10 past end");
    chk("R10 res", res_code, 8'h11);
    do_read(0, 8'h00, 1, "R10 undefined reads 0 at ptr 0x09");
    wq = '{8'hFF};
    do_write(8'h05, "R10 status write");
    do_read(1, 8'h05, 1, "R10 status unchanged");

    // R1: foreign address ignored
    oe_cnt = 0;
    bus_start();
    send_byte({7'h0F, 1'b0}, ack);
    chk("R1 foreign NACK", ack, 0);
    send_byte(8'h07, ack);
    send_byte(8'hAA, ack);
    bus_stop();
    chk("R1 foreign never drives", oe_cnt, 0);
    chk("R1 foreign no write", res_code, 8'h11);

    // R2: STOP inside a data byte discards it
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h07, ack);
    m_ptr = 8'h07;
    put_bit(0); put_bit(1); put_bit(0); put_bit(1);
    bus_stop();
    chk("R2 aborted byte dropped", res_code, 8'h11);
    do_read(0, 8'h00, 1, "R2 ptr kept at 0x07");

    // R11/R9: enable bit, then soft reset
    wq = '{8'h00};
    do_write(8'h02, "R11 ring off");
    chk("R11 ring_en off", ring_en, 0);
    wq = '{8'h01};
    do_write(8'h02, "R9 soft reset");
    chk("R9 soft pulse count", soft_cnt, 1);
    chk("R9 current cleared", current, 0);
    chk("R9 res default", res_code, 8'h83);
    do_read(1, 8'h02, 6, "R9 map after reset");
    chk("R8 total commits", commit_cnt, exp_commit);
    chk("R9 total soft", soft_cnt, exp_soft);

    done = 1;
    hw(4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule